// File: doc/BRIEF.md
# Flash Program Interlock Controller

This block guards the programming path of an on-chip flash array. Before the array may receive its programming high voltage, software must walk through a fixed sequence. It opens a programming session in a control register. It then makes one write to the array, which captures both the target address and the data word. Only after that may it raise the high-voltage enable. Array writes made later in the sequence can refresh only the data word. The address stays pinned to the first capture. Each state also limits which control bits a register write may change.

While the high voltage is on, the array is reported busy and array writes are dropped. Programming may be suspended by a control bit or by disabling the module, and it resumes from the same point. While suspended and enabled, the array serves reads again. The word under programming is flagged so that its read data can be forced to all ones. A shadow-select bit, set before the sequence starts, redirects programming to the small shadow row and keeps only the low address bits. A cycle counter stands in for the programming pulse. It reports completion after a configurable number of cycles in the programming state and holds its count while suspended.

The bus is single-cycle. A write or read is presented with `bus_valid` for one clock, and `bus_is_reg` selects the control register rather than the array.

Top module: `flash_prog_interlock`

## Requirements
- R1: After a synchronous reset the controller is idle. `hv_req`, `arr_busy` and `rd_ones` are 0, `reg_rdata` is 0, and `prog_addr` and `prog_data` are 0.
- R2: Control word bits are: bit0 session enable, bit1 high-voltage enable, bit2 suspend, bit3 shadow select. Read-only status is at bit4 (high voltage active) and bit5 (done). Writing bit0=1 from idle arms the controller. While armed, a write cannot set the high-voltage enable bit.
- R3: In the armed state the first array write captures both address and data and moves the controller to loaded. A register write while armed stores no data and leaves the controller armed.
- R4: In the loaded state an array write updates `prog_data` only. `prog_addr` keeps the first captured address.
- R5: Writing high-voltage enable to 1 while loaded enters programming. `hv_req` and `arr_busy` are 1 from the next cycle. Writing it to 0 while programming returns to loaded, with `hv_req` 0 the next cycle.
- R6: While programming, array writes are ignored, and register writes change only the high-voltage enable and suspend bits.
- R7: Setting suspend, or driving `mod_en` low, while programming enters the suspended state. Status bit4 and `hv_req` read 0 there, and `arr_busy` is 1 only when `mod_en` is low. Clearing suspend with `mod_en` high, or raising `mod_en` with suspend clear, returns to programming.
- R8: While suspended with `mod_en` high, an array read of `prog_addr` raises `rd_ones` in the same cycle. A read of any other address does not.
- R9: Writing session enable to 0 while armed or loaded returns to idle and clears `prog_addr` and `prog_data`.
- R10: Reset while programming or suspended returns directly to idle, with all outputs as in R1.
- R11: With shadow select written to 1 in idle or armed, the captured address keeps only its low SHADOW_AW bits, and `prog_shadow` is 1.
- R12: After PULSE_CYC cycles in the programming state, status bit5 (done) is set and `hv_req` drops. The count holds while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_is_reg | input | 1 | 1 = control register, 0 = array |
| bus_addr | input | AW | Array address |
| bus_wdata | input | DW | Write data |
| mod_en | input | 1 | Module enable; low disables the array |
| reg_rdata | output | DW | Control word and status |
| hv_req | output | 1 | High-voltage pump request |
| arr_busy | output | 1 | Array not responding to access |
| rd_ones | output | 1 | Force current array read data to all ones |
| prog_addr | output | AW | Latched program address |
| prog_data | output | DW | Latched program data |
| prog_shadow | output | 1 | Programming targets the shadow row |

## Verification
The pulse counter can expire in the same cycle that a suspend write is accepted. The controller must then both set done and enter the suspended state, without losing either event. The bench provokes this by counting programming cycles and placing the suspend write on the edge where the count reaches its limit. It then checks that the done bit, the suspend bit and a low `hv_req` are all seen together. A second overlap is the module-disable input falling while the control bits say to keep programming. The bench checks that the controller still suspends.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_LOADED = 3'd2,
        ST_PROG   = 3'd3,
        ST_SUSP   = 3'd4
    } fpi_state_e;

    // control word, bit3..bit0
    typedef struct packed {
        logic shadow;
        logic susp;
        logic hv_en;
        logic sess;
    } fpi_ctrl_t;

    localparam int CTRL_W = $bits(fpi_ctrl_t);

    // bits a register write may change in each state
    function automatic fpi_ctrl_t wr_mask(fpi_state_e s);
        fpi_ctrl_t m;
        m = '0;
        case (s)
            ST_IDLE, ST_ARMED: begin m.sess = 1'b1; m.shadow = 1'b1; end
            ST_LOADED:         begin m.sess = 1'b1; m.hv_en = 1'b1; end
            ST_PROG:           begin m.hv_en = 1'b1; m.susp = 1'b1; end
            ST_SUSP:           begin m.susp = 1'b1; end
            default:           m = '0;
        endcase
        return m;
    endfunction

    function automatic fpi_ctrl_t merge_ctrl(fpi_ctrl_t old, fpi_ctrl_t nw, fpi_ctrl_t m);
        return fpi_ctrl_t'((old & ~m) | (nw & m));
    endfunction

endpackage

// File: rtl/fpi_fsm.sv
module fpi_fsm
    import fpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  fpi_ctrl_t  wr_val,
    input  logic       arr_wr,
    input  logic       mod_en,
    output fpi_state_e state_q,
    output fpi_ctrl_t  ctrl_q,
    output logic       cap_addr,
    output logic       cap_data,
    output logic       clr_latch
);

    fpi_state_e st_n;
    fpi_ctrl_t  cand;
    fpi_ctrl_t  ctrl_n;

    always_comb begin
        cand     = reg_wr ? merge_ctrl(ctrl_q, wr_val, wr_mask(state_q)) : ctrl_q;
        ctrl_n   = cand;
        st_n     = state_q;
        cap_addr = 1'b0;
        cap_data = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cand.sess) st_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (!cand.sess) begin
                    st_n = ST_IDLE;
                end else if (arr_wr) begin
                    st_n     = ST_LOADED;
                    cap_addr = 1'b1;
                    cap_data = 1'b1;
                end
            end
            ST_LOADED: begin
                if (!cand.sess)       st_n = ST_IDLE;
                else if (cand.hv_en)  st_n = ST_PROG;
                else if (arr_wr)      cap_data = 1'b1;
            end
            ST_PROG: begin
                if (!cand.hv_en) begin
                    st_n        = ST_LOADED;
                    ctrl_n.susp = 1'b0;
                end else if (cand.susp || !mod_en) begin
                    st_n = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (!cand.susp && mod_en) st_n = ST_PROG;
            end
            default: st_n = ST_IDLE;
        endcase
        if (st_n == ST_IDLE) begin
            ctrl_n.hv_en = 1'b0;
            ctrl_n.susp  = 1'b0;
        end
        clr_latch = (st_n == ST_IDLE) && (state_q != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
        end else begin
            state_q <= st_n;
            ctrl_q  <= ctrl_n;
        end
    end

endmodule

// File: rtl/fpi_latch.sv
module fpi_latch #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int SAW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_addr,
    input  logic          cap_data,
    input  logic          clr,
    input  logic          shadow,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    localparam logic [AW-1:0] SH_MASK = {{(AW-SAW){1'b0}}, {SAW{1'b1}}};

    logic [AW-1:0] addr_sel;

    generate
        if (SAW >= AW) begin : g_full
            assign addr_sel = addr_in;
        end else begin : g_mask
            assign addr_sel = shadow ? (addr_in & SH_MASK) : addr_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (cap_addr) addr_q <= addr_sel;
            if (cap_data) data_q <= data_in;
        end
    end

endmodule

// File: rtl/fpi_timer.sv
module fpi_timer
    import fpi_pkg::*;
#(
    parameter int PULSE_CYC = 16,
    parameter int CW        = $clog2(PULSE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fpi_state_e    state,
    output logic [CW-1:0] cnt_q,
    output logic          done_q
);

    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    logic active;
    assign active = (state == ST_PROG) || (state == ST_SUSP);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (state == ST_PROG && !done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) done_q <= 1'b1;
        end
    end

endmodule

// File: rtl/flash_prog_interlock.sv
module flash_prog_interlock
    import fpi_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int SHADOW_AW = 4,
    parameter int PULSE_CYC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic          bus_is_reg,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          mod_en,
    output logic [DW-1:0] reg_rdata,
    output logic          hv_req,
    output logic          arr_busy,
    output logic          rd_ones,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          prog_shadow
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    fpi_state_e    state_q;
    fpi_ctrl_t     ctrl_q;
    logic          reg_wr, arr_wr, arr_rd;
    logic          cap_addr, cap_data, clr_latch;
    logic          done_q;
    logic [CW-1:0] cnt_q;

    assign reg_wr = bus_valid && bus_write && bus_is_reg;
    assign arr_wr = bus_valid && bus_write && !bus_is_reg;
    assign arr_rd = bus_valid && !bus_write && !bus_is_reg;

    fpi_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .wr_val    (fpi_ctrl_t'(bus_wdata[CTRL_W-1:0])),
        .arr_wr    (arr_wr),
        .mod_en    (mod_en),
        .state_q   (state_q),
        .ctrl_q    (ctrl_q),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .clr_latch (clr_latch)
    );

    fpi_latch #(.AW(AW), .DW(DW), .SAW(SHADOW_AW)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .clr      (clr_latch),
        .shadow   (ctrl_q.shadow),
        .addr_in  (bus_addr),
        .data_in  (bus_wdata),
        .addr_q   (prog_addr),
        .data_q   (prog_data)
    );

    fpi_timer #(.PULSE_CYC(PULSE_CYC), .CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .state  (state_q),
        .cnt_q  (cnt_q),
        .done_q (done_q)
    );

    assign hv_req      = (state_q == ST_PROG) && !done_q;
    assign arr_busy    = (state_q == ST_PROG) || ((state_q == ST_SUSP) && !mod_en);
    assign rd_ones     = (state_q == ST_SUSP) && mod_en && arr_rd && (bus_addr == prog_addr);
    assign prog_shadow = ctrl_q.shadow;

    always_comb begin
        reg_rdata = '0;
        reg_rdata[CTRL_W-1:0] = ctrl_q;
        reg_rdata[CTRL_W]     = hv_req;
        reg_rdata[CTRL_W+1]   = done_q;
    end

endmodule

// File: rtl/fpi_chk.sv
module fpi_chk
    import fpi_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input fpi_state_e    state_q,
    input logic [AW-1:0] prog_addr,
    input logic [DW-1:0] prog_data,
    input logic          hv_req,
    input logic          arr_busy,
    input logic [DW-1:0] reg_rdata,
    input logic [CW-1:0] cnt_q
);

    // hv request only with the enable bit set and the array blocked
    p_hv_gated_r5: assert property (@(posedge clk) disable iff (rst)
        hv_req |-> (reg_rdata[1] && arr_busy));

    // armed state never holds the high-voltage enable
    p_armed_no_hv_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED) |-> !reg_rdata[1]);

    // address stays fixed while loaded
    p_addr_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOADED && $past(state_q) == ST_LOADED) |-> $stable(prog_addr));

    // data latch untouched during programming
    p_prog_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> $stable(prog_data));

    // suspended: no high voltage, status bit reads 0
    p_susp_no_hv_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP) |-> (!hv_req && !reg_rdata[4]));

    // idle means empty latches
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (prog_addr == '0 && prog_data == '0));

    // pulse count frozen while suspended
    p_cnt_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP && $past(state_q) == ST_SUSP) |-> $stable(cnt_q));

endmodule

bind flash_prog_interlock fpi_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .hv_req    (hv_req),
    .arr_busy  (arr_busy),
    .reg_rdata (reg_rdata),
    .cnt_q     (cnt_q)
);

// File: tb/sim_flash_prog_interlock.sv
`timescale 1ns/1ps
module sim_flash_prog_interlock;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SAW = 4;
    localparam int P = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0, bus_write = 1'b0, bus_is_reg = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          mod_en = 1'b1;
    logic [DW-1:0] reg_rdata;
    logic          hv_req, arr_busy, rd_ones, prog_shadow;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_prog_interlock #(.AW(AW), .DW(DW), .SHADOW_AW(SAW), .PULSE_CYC(P)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_is_reg(bus_is_reg), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mod_en(mod_en), .reg_rdata(reg_rdata), .hv_req(hv_req),
        .arr_busy(arr_busy), .rd_ones(rd_ones), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_shadow(prog_shadow)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; mod_en = 1'b1;
        bus_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wreg(input logic [3:0] v);
        bus_valid = 1'b1; bus_write = 1'b1; bus_is_reg = 1'b1;
        bus_wdata = {28'h0, v};
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic warr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_is_reg = 1'b0;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rarr(input logic [AW-1:0] a, output logic ones);
        bus_valid = 1'b1; bus_write = 1'b0; bus_is_reg = 1'b0; bus_addr = a;
        #1 ones = rd_ones;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic go_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        do_reset();
        wreg(4'b0001);
        warr(a, d);
        wreg(4'b0011);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reg_rdata", reg_rdata, 0);
        check("R1 hv/busy/ones", {hv_req, arr_busy, rd_ones}, 0);
        check("R1 latches", {prog_addr, prog_data}, 0);
    endtask

    task automatic t_arm();
        do_reset();
        wreg(4'b0001);
        check("R2 armed sess", reg_rdata[5:0], 6'h01);
        wreg(4'b0011);
        check("R2 hv blocked in armed", {reg_rdata[1], hv_req, arr_busy}, 0);
    endtask

    task automatic t_capture();
        do_reset();
        wreg(4'b0001);
        wreg(4'b0001);
        check("R3 reg write stores no data", {prog_addr, prog_data}, 0);
        wreg(4'b0011);
        check("R3 still armed, hv not set", reg_rdata[1], 0);
        warr(16'h0120, 32'hCAFE0001);
        check("R3 capture addr", prog_addr, 16'h0120);
        check("R3 capture data", prog_data, 32'hCAFE0001);
    endtask

    task automatic t_loaded();
        do_reset();
        wreg(4'b0001);
        warr(16'h0200, 32'h11111111);
        warr(16'h0999, 32'h22222222);
        check("R4 data updated", prog_data, 32'h22222222);
        check("R4 addr fixed", prog_addr, 16'h0200);
    endtask

    task automatic t_prog_enter_exit();
        go_prog(16'h0040, 32'hA5A5A5A5);
        check("R5 enter prog", {hv_req, arr_busy, reg_rdata[4]}, 3'b111);
        wreg(4'b0000);
        check("R5 exit prog hv_req", {hv_req, arr_busy}, 0);
        check("R5 back to loaded sess", reg_rdata[1:0], 2'b01);
    endtask

    task automatic t_prog_ignore();
        go_prog(16'h0044, 32'h12345678);
        warr(16'h0044, 32'hFFFF0000);
        check("R6 array write ignored", prog_data, 32'h12345678);
        wreg(4'b1010);
        check("R6 only hv/susp writable", reg_rdata[3:0], 4'b0011);
        check("R6 still programming", hv_req, 1'b1);
    endtask

    task automatic t_suspend();
        logic o;
        go_prog(16'h0050, 32'h0);
        wreg(4'b0110);
        check("R7 suspend by bit", {hv_req, reg_rdata[4], arr_busy}, 0);
        check("R7 suspend bit set", reg_rdata[2], 1'b1);
        wreg(4'b0010);
        check("R7 resume", {hv_req, arr_busy}, 2'b11);
        mod_en = 1'b0;
        @(negedge clk);
        check("R7 disable suspends, busy", {hv_req, arr_busy}, 2'b01);
        rarr(16'h0050, o);
        check("R8 no forced read when disabled", o, 0);
        mod_en = 1'b1;
        @(negedge clk);
        check("R7 re-enable resumes", {hv_req, arr_busy}, 2'b11);
    endtask

    task automatic t_susp_read();
        logic o;
        go_prog(16'h0077, 32'h5);
        wreg(4'b0110);
        rarr(16'h0077, o);
        check("R8 read of prog addr all ones", o, 1'b1);
        rarr(16'h0078, o);
        check("R8 other addr normal", o, 1'b0);
    endtask

    task automatic t_cancel();
        do_reset();
        wreg(4'b0001);
        warr(16'h0300, 32'h9);
        wreg(4'b0000);
        check("R9 cancel from loaded", {reg_rdata[5:0], prog_addr, prog_data}, 0);
        wreg(4'b0001);
        wreg(4'b0000);
        check("R9 cancel from armed", reg_rdata[5:0], 0);
    endtask

    task automatic t_reset_mid();
        go_prog(16'h0010, 32'h3);
        do_reset();
        check("R10 reset from prog", {reg_rdata[5:0], hv_req, arr_busy, prog_addr, prog_data}, 0);
        go_prog(16'h0010, 32'h3);
        wreg(4'b0110);
        do_reset();
        check("R10 reset from susp", {reg_rdata[5:0], hv_req, arr_busy, prog_addr, prog_data}, 0);
    endtask

    task automatic t_shadow();
        do_reset();
        wreg(4'b1001);
        warr(16'h1237, 32'h77);
        check("R11 shadow addr masked", prog_addr, 16'h0007);
        check("R11 shadow flag", prog_shadow, 1'b1);
    endtask

    task automatic t_timer();
        go_prog(16'h0020, 32'h1);
        repeat (P-1) @(negedge clk);
        check("R12 not done before limit", {reg_rdata[5], hv_req}, 2'b01);
        @(negedge clk);
        check("R12 done at limit", {reg_rdata[5], hv_req}, 2'b10);
        go_prog(16'h0020, 32'h1);
        repeat (3) @(negedge clk);
        wreg(4'b0110);
        repeat (10) @(negedge clk);
        wreg(4'b0010);
        repeat (P-5) @(negedge clk);
        check("R12 count held in suspend", reg_rdata[5], 1'b0);
        @(negedge clk);
        check("R12 done after resume", {reg_rdata[5], hv_req}, 2'b10);
    endtask

    task automatic t_collide();
        go_prog(16'h0030, 32'h2);
        repeat (P-1) @(negedge clk);
        wreg(4'b0110);
        check("R12 R7 expiry with suspend", {reg_rdata[5], reg_rdata[2], hv_req, arr_busy}, 4'b1100);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arm();
        t_capture();
        t_loaded();
        t_prog_enter_exit();
        t_prog_ignore();
        t_suspend();
        t_susp_read();
        t_cancel();
        t_reset_mid();
        t_shadow();
        t_timer();
        t_collide();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule